// File: doc/BRIEF.md
# Boot EEPROM Reset-Configuration Loader

This block sits behind a serial-bus reader that streams bytes out of a boot EEPROM in address order. After a start pulse it takes those bytes over a valid/ready handshake. It first checks that the stream opens with a fixed three-byte signature. It then decodes two seven-byte records, one for the high reset configuration word and one for the low. Each record turns into one register write on a simple write port, which carries an address, a data word and byte enables.

Each record has a three-byte header and four data bytes. The header holds flag bits and an 18-bit word offset. The data word is stored most significant byte first. The write address places a programmable base above the byte form of the offset. No checksum is read in this mode. After the second write the loader stops taking bytes and holds a done flag. A bad signature byte or a malformed header ends the load with an error flag, and no further writes are issued.

Top module: `rcw_loader`

## Requirements
- R1: After synchronous reset, in_ready, wr_en, done and error are all low, and the block takes no bytes until start is pulsed.
- R2: The first three accepted bytes must be 0xAA, 0x55, 0xAA in that order. A mismatching byte raises error in the cycle after it is accepted, and no write is then issued.
- R3: In the first header byte, bit 0 is an alternate-space flag that must be 0. Bits 4:1 are byte enables that must all be 1, bit 5 is a continue flag that must be 1, and bits 7:6 are offset bits 17:16. Any other value of bits 5:0 (anything but 0x3E) raises error in the next cycle and stops all later writes. wr_be carries bits 4:1 of the header, so it is always 4'hF on a write.
- R4: The second header byte is offset bits 15:8 and the third is offset bits 7:0. The write address is {base_addr, offset[17:0], 2'b00}.
- R5: The four data bytes form wr_data most significant byte first.
- R6: A load produces exactly two writes: the first record's write, then the second record's. Each write is a one-cycle wr_en pulse, issued in the cycle after the record's last data byte is accepted.
- R7: done rises in the cycle after the second write and stays high until the next start. While done is high, in_ready is low, so trailing bytes are neither taken nor written.
- R8: in_ready is low whenever wr_en is high, and also while idle, done or in error.
- R9: A start pulse in any state clears done and error and begins a new load with the signature check.
- R10: done and error are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a load |
| base_addr | input | ADDR_W-20 | Base placed above the byte offset |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | Loader can take a byte |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Write byte enables |
| done | output | 1 | Both words written |
| error | output | 1 | Load aborted |

## Verification
Valid loads use random bases, offsets and data words, with random idle gaps between bytes. These loads separate correct byte order, offset splitting and base placement from swapped or shifted fields. Corrupted loads change one signature byte or the flag bits of either header. They show that the check happens at the right point, since a bad second header still lets the first write through. Further directed runs cover the exact cycle of the write and done, trailing bytes pushed after done, and a restart in the middle of a load.

// File: rtl/rcw_loader.sv
module rcw_loader #(
  parameter int          ADDR_W   = 32,
  parameter logic [23:0] PREAMBLE = 24'hAA55AA
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [ADDR_W-21:0]   base_addr,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [31:0]          wr_data,
  output logic [3:0]           wr_be,
  output logic                 done,
  output logic                 error
);
  localparam int OFF_W = 18;
  localparam logic [5:0] HDR_FLAGS = 6'h3E;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_HDR, S_DAT, S_WR, S_DONE, S_ERR} st_t;

  st_t              st;
  logic [1:0]       idx;
  logic             rec;
  logic [OFF_W-1:0] off;
  logic [3:0]       be;
  logic [31:0]      dq;
  logic [7:0]       pre_exp;

  assign in_ready = (st == S_PRE) || (st == S_HDR) || (st == S_DAT);
  wire   take     = in_valid && in_ready;
  wire   hdr_ok   = in_data[5:0] == HDR_FLAGS;

  always_comb begin
    case (idx)
      2'd0:    pre_exp = PREAMBLE[23:16];
      2'd1:    pre_exp = PREAMBLE[15:8];
      default: pre_exp = PREAMBLE[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      idx <= '0;
      rec <= 1'b0;
      off <= '0;
      be  <= '0;
      dq  <= '0;
    end else if (start) begin
      st  <= S_PRE;
      idx <= '0;
      rec <= 1'b0;
    end else begin
      case (st)
        S_PRE: if (take) begin
          if (in_data != pre_exp) st <= S_ERR;
          else if (idx == 2'd2) begin
            st  <= S_HDR;
            idx <= '0;
          end else idx <= idx + 2'd1;
        end
        S_HDR: if (take) begin
          case (idx)
            2'd0: begin
              if (!hdr_ok) st <= S_ERR;
              else begin
                off[17:16] <= in_data[7:6];
                be         <= in_data[4:1];
                idx        <= 2'd1;
              end
            end
            2'd1: begin
              off[15:8] <= in_data;
              idx       <= 2'd2;
            end
            default: begin
              off[7:0] <= in_data;
              idx      <= '0;
              st       <= S_DAT;
            end
          endcase
        end
        S_DAT: if (take) begin
          dq <= {dq[23:0], in_data};
          if (idx == 2'd3) begin
            idx <= '0;
            st  <= S_WR;
          end else idx <= idx + 2'd1;
        end
        S_WR: begin
          if (rec) st <= S_DONE;
          else begin
            rec <= 1'b1;
            st  <= S_HDR;
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en   = st == S_WR;
  assign wr_addr = {base_addr, off, 2'b00};
  assign wr_data = dq;
  assign wr_be   = be;
  assign done    = st == S_DONE;
  assign error   = st == S_ERR;

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !in_ready && !wr_en && !done && !error);
  p_pre_err_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_PRE && take && in_data != pre_exp && !start) |=> error);
  p_err_nowr_r2: assert property (@(posedge clk) disable iff (rst) error |-> !wr_en);
  p_hdr_err_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_HDR && idx == 2'd0 && take && !hdr_ok && !start) |=> error);
  p_be_full_r3: assert property (@(posedge clk) disable iff (rst) wr_en |-> wr_be == 4'hF);
  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (rst) wr_en |=> !wr_en);
  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> done);
  p_done_noin_r7: assert property (@(posedge clk) disable iff (rst) done |-> !in_ready);
  p_ready_wr_r8: assert property (@(posedge clk) disable iff (rst) wr_en |-> !in_ready);
  p_start_clear_r9: assert property (@(posedge clk) disable iff (rst) start |=> !done && !error);
  p_excl_r10: assert property (@(posedge clk) disable iff (rst) !(done && error));
endmodule

// File: tb/sim_rcw_loader.sv
module sim_rcw_loader;
  localparam int ADDR_W = 32;
  localparam int BW = ADDR_W - 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [BW-1:0] base_addr = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, wr_en, done, error;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] wr_be;

  always #10 clk = ~clk;

  rcw_loader #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .done(done), .error(error));

  int n_chk = 0, n_bad = 0;
  int nw = 0;
  logic [ADDR_W-1:0] cap_a [4];
  logic [31:0] cap_d [4];
  logic [3:0]  cap_b [4];
  logic [7:0]  strm [17];
  int cyc = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (wr_en) begin
      if (nw < 4) begin
        cap_a[nw] = wr_addr;
        cap_d[nw] = wr_data;
        cap_b[nw] = wr_be;
      end
      nw = nw + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [BW-1:0] b, input logic [17:0] o);
    return {b, o, 2'b00};
  endfunction

  function automatic logic [7:0] hdr0(input logic [17:0] o);
    return {o[17:16], 6'b111110};
  endfunction

  task automatic build(input logic [17:0] o0, input logic [31:0] d0,
                       input logic [17:0] o1, input logic [31:0] d1);
    strm[0] = 8'hAA; strm[1] = 8'h55; strm[2] = 8'hAA;
    strm[3] = hdr0(o0); strm[4] = o0[15:8]; strm[5] = o0[7:0];
    strm[6] = d0[31:24]; strm[7] = d0[23:16]; strm[8] = d0[15:8]; strm[9] = d0[7:0];
    strm[10] = hdr0(o1); strm[11] = o1[15:8]; strm[12] = o1[7:0];
    strm[13] = d1[31:24]; strm[14] = d1[23:16]; strm[15] = d1[15:8]; strm[16] = d1[7:0];
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nw = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit gaps);
    if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    while (!in_ready && !error) @(negedge clk);
    if (!error) @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (error) break;
      send(strm[i], gaps);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_two(input logic [BW-1:0] b, input logic [17:0] o0, input logic [31:0] d0,
                           input logic [17:0] o1, input logic [31:0] d1);
    chk(nw == 2, "R6 write count", nw, 2);
    chk(cap_a[0] == exp_addr(b, o0), "R4 addr first", cap_a[0], exp_addr(b, o0));
    chk(cap_d[0] == d0, "R5 data first", cap_d[0], d0);
    chk(cap_a[1] == exp_addr(b, o1), "R4 addr second", cap_a[1], exp_addr(b, o1));
    chk(cap_d[1] == d1, "R5 data second", cap_d[1], d1);
    chk(cap_b[0] == 4'hF && cap_b[1] == 4'hF, "R3 byte enables", {cap_b[0], cap_b[1]}, 8'hFF);
    chk(done && !error, "R7 done", {done, error}, 2'b10);
  endtask

  initial begin
    logic [17:0] o0, o1;
    logic [31:0] d0, d1;
    logic [BW-1:0] b;
    void'($urandom(32'h5EED_0123));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!in_ready && !wr_en && !done && !error, "R1 reset state",
        {in_ready, wr_en, done, error}, 0);
    in_valid = 1'b1; in_data = 8'hAA;
    repeat (2) @(negedge clk);
    chk(!in_ready && !done && !error, "R1 idle ignores bytes", {in_ready, done, error}, 0);
    in_valid = 1'b0;

    // Directed: exact timing of write and done (R6, R7)
    b = 12'hF01; base_addr = b;
    o0 = 18'h3_C0DE; d0 = 32'h1234_5678; o1 = 18'h0_0001; d1 = 32'h8000_00FF;
    build(o0, d0, o1, d1);
    pulse_start();
    for (int i = 0; i < 16; i++) send(strm[i], 1'b0);
    in_valid = 1'b1; in_data = strm[16];
    @(negedge clk);
    in_valid = 1'b0;
    chk(wr_en, "R6 write one cycle after last byte", wr_en, 1);
    chk(!in_ready, "R8 ready low during write", in_ready, 0);
    @(negedge clk);
    chk(!wr_en && done, "R7 done after second write", {wr_en, done}, 2'b01);
    in_valid = 1'b1; in_data = 8'h3E;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    chk(nw == 2 && done && !in_ready, "R7 trailing bytes ignored", {nw[3:0], done, in_ready}, {4'd2, 2'b10});
    check_two(b, o0, d0, o1, d1);

    // Directed: restart mid-load (R9)
    pulse_start();
    chk(!done && !error, "R9 start clears done", {done, error}, 0);
    for (int i = 0; i < 5; i++) send(strm[i], 1'b0);
    o0 = 18'h2_AAAA; d0 = 32'hCAFE_F00D; o1 = 18'h1_5555; d1 = 32'h0BAD_BEEF;
    build(o0, d0, o1, d1);
    pulse_start();
    feed(17, 1'b1);
    check_two(b, o0, d0, o1, d1);

    // Directed: bad preamble timing (R2)
    pulse_start();
    send(8'hAA, 1'b0);
    in_valid = 1'b1; in_data = 8'h54;
    @(negedge clk);
    in_valid = 1'b0;
    chk(error && !done, "R2 error after bad preamble byte", {error, done}, 2'b10);
    chk(!in_ready, "R8 ready low in error", in_ready, 0);

    // Random mix of valid and corrupted loads
    for (int t = 0; t < 60; t++) begin
      int kind, pos;
      b = BW'($urandom); base_addr = b;
      o0 = 18'($urandom); o1 = 18'($urandom);
      d0 = $urandom; d1 = $urandom;
      build(o0, d0, o1, d1);
      kind = $urandom_range(0, 3);
      pos = 0;
      if (kind == 1) begin
        pos = $urandom_range(0, 2);
        strm[pos] = strm[pos] ^ 8'($urandom_range(1, 255));
      end else if (kind >= 2) begin
        pos = (kind == 2) ? 3 : 10;
        strm[pos] = strm[pos] ^ {2'b00, 6'($urandom_range(1, 63))};
      end
      pulse_start();
      feed(17, 1'b1);
      if (kind == 0) check_two(b, o0, d0, o1, d1);
      else if (kind == 1) begin
        chk(error && !done, "R2 random bad preamble", {error, done}, 2'b10);
        chk(nw == 0, "R2 no write after bad preamble", nw, 0);
      end else begin
        chk(error && !done, "R3 random bad header", {error, done}, 2'b10);
        chk(nw == kind - 2, "R3 writes before bad header", nw, kind - 2);
        if (kind == 3)
          chk(cap_a[0] == exp_addr(b, o0) && cap_d[0] == d0, "R4 R5 first write kept",
              cap_d[0], d0);
      end
    end

    // Start clears error (R9, R10)
    pulse_start();
    chk(!error && !done && in_ready, "R9 start clears error", {error, done, in_ready}, 3'b001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule